// File: doc/BRIEF.md
# Memory Access Permission Checker

This block decides whether a single memory access may proceed under a set of protection regions. Each request carries a byte address, an access size, the set of permissions it needs (read, write, execute) and the privilege mode of the requester. The block compares the access against every region in parallel. The lowest-numbered active region that touches the access decides the outcome. If no region touches the access, a default policy applies instead. The block returns a grant flag and the 3-bit set of permissions that the deciding rule allows.

Region bounds arrive already decoded as inclusive low and high byte addresses, one pair per entry. Each entry also has a configuration byte. Two global security controls select the policy: one turns on lockdown tables, and one makes unmatched accesses fail for every mode.

Requests enter on a valid/ready port. The result leaves on a second valid/ready port after one register stage. A request is taken when `in_valid` and `in_ready` are both high. `in_ready` is high when the output slot is empty or when the output is being consumed in the same cycle. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new request is taken. The region and security inputs are plain control pins and are sampled when a request is taken.

Top module: `pmp_access_checker`

## Requirements
- R1: A request taken on one clock edge gives `out_valid` high after that edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_grant` and `out_allowed` hold their values. After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Permission masks and the low bits of a configuration byte share one encoding: bit0 = read, bit1 = write, bit2 = execute. In the configuration byte, bits 4:3 give the match mode, where 00 means off and any other value means active. Bit 7 of the configuration byte is the lock. An entry that is off never matches.
- R3: Entries are searched from index 0 upward. The first active entry whose inclusive range holds the access's first byte or its last byte decides the result, and later entries are ignored.
- R4: The access spans addr through addr+size−1, modulo 2^ADDR_W, where size ≥ 1. If the deciding entry holds exactly one of those two bytes, the access is denied: grant is 0 and the allowed mask is 000.
- R5: With lockdown off, a fully matching entry allows RWX to machine mode (mode code 3) when the entry is unlocked. For any other mode code, or for a locked entry, it allows only the entry's own RWX bits.
- R6: With lockdown on, a matching machine-mode access is looked up by the index {L,R,W,X}. Index 2, 3 or 14 gives RW. Index 9 or 10 gives X. Index 11 or 13 gives RX. Index 12 or 15 gives R. Every other index gives nothing.
- R7: With lockdown on, a matching access from any other mode is looked up by the same index. Index 7 gives RWX. Index 5 gives RX. Index 3 or 6 gives RW. Index 2, 4 or 15 gives R. Index 1, 10 or 11 gives X. Every other index gives nothing.
- R8: When no entry matches and the deny-default control is set, the allowed mask is 000 and grant is 0 for every mode.
- R9: When no entry matches, deny-default is clear and lockdown is on, a machine-mode request that does not ask for execute is allowed RW and granted. Any other request is allowed nothing and denied.
- R10: When no entry matches and both controls are clear, machine mode is allowed RWX and granted. Other modes are allowed nothing and denied.
- R11: When an entry fully matches, grant is 1 exactly when every requested permission bit is also set in the allowed mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_addr | input | ADDR_W | First byte address of the access |
| in_size | input | SIZE_W | Access size in bytes (≥ 1) |
| in_req | input | 3 | Requested permissions {X,W,R} |
| in_mode | input | 2 | Privilege mode: 0 user, 1 supervisor, 3 machine |
| region_lo | input | NUM_ENTRIES*ADDR_W | Inclusive low byte address of each entry |
| region_hi | input | NUM_ENTRIES*ADDR_W | Inclusive high byte address of each entry |
| entry_cfg | input | NUM_ENTRIES*8 | Configuration byte of each entry |
| sec_lockdown | input | 1 | Selects the lockdown permission tables |
| sec_deny_default | input | 1 | Unmatched accesses are denied for all modes |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result consumer can accept |
| out_grant | output | 1 | Access permitted |
| out_allowed | output | 3 | Allowed permission mask {X,W,R} |

## Verification
The bound checker checks the handshake on every cycle: the result holds while stalled, a taken request always produces a result, and a granted result never lacks a requested permission. It also checks the three default-policy outcomes whenever no entry is active. Search order, partial-overlap denial and the full contents of both lockdown tables depend on particular region layouts, so only the bench's directed scenarios show them. In those scenarios the bench sweeps all sixteen {L,R,W,X} indices for each privilege class and places overlapping and straddling regions at chosen indices.

// File: rtl/pmpc_pkg.sv
package pmpc_pkg;
  typedef logic [2:0] perm_t;

  localparam perm_t PERM_NONE = 3'b000;
  localparam perm_t PERM_R    = 3'b001;
  localparam perm_t PERM_W    = 3'b010;
  localparam perm_t PERM_X    = 3'b100;
  localparam perm_t PERM_RW   = 3'b011;
  localparam perm_t PERM_RX   = 3'b101;
  localparam perm_t PERM_RWX  = 3'b111;

  localparam int CFG_R_BIT    = 0;
  localparam int CFG_W_BIT    = 1;
  localparam int CFG_X_BIT    = 2;
  localparam int CFG_MODE_LSB = 3;
  localparam int CFG_LOCK_BIT = 7;

  localparam logic [1:0] PRIV_MACHINE = 2'd3;
endpackage

// File: rtl/pmpc_entry_cmp.sv
module pmpc_entry_cmp #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] first_addr,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic [1:0]        match_mode,
  output logic              touch,
  output logic              straddle
);
  logic active;
  logic first_in;
  logic last_in;

  always_comb begin
    active   = (match_mode != 2'b00);
    first_in = (first_addr >= lo) && (first_addr <= hi);
    last_in  = (last_addr >= lo) && (last_addr <= hi);
    touch    = active && (first_in || last_in);
    straddle = first_in ^ last_in;
  end
endmodule

// File: rtl/pmpc_perm_lookup.sv
module pmpc_perm_lookup
  import pmpc_pkg::*;
(
  input  logic  lockdown,
  input  logic  machine,
  input  logic  lock,
  input  logic  r,
  input  logic  w,
  input  logic  x,
  output perm_t perm
);
  logic [3:0] idx;

  always_comb begin
    idx  = {lock, r, w, x};
    perm = PERM_NONE;
    if (!lockdown) begin
      if (machine && !lock) perm = PERM_RWX;
      else                  perm = {x, w, r};
    end else if (machine) begin
      case (idx)
        4'd2, 4'd3, 4'd14: perm = PERM_RW;
        4'd9, 4'd10:       perm = PERM_X;
        4'd11, 4'd13:      perm = PERM_RX;
        4'd12, 4'd15:      perm = PERM_R;
        default:           perm = PERM_NONE;
      endcase
    end else begin
      case (idx)
        4'd7:              perm = PERM_RWX;
        4'd5:              perm = PERM_RX;
        4'd3, 4'd6:        perm = PERM_RW;
        4'd2, 4'd4, 4'd15: perm = PERM_R;
        4'd1, 4'd10, 4'd11: perm = PERM_X;
        default:           perm = PERM_NONE;
      endcase
    end
  end
endmodule

// File: rtl/pmpc_default_policy.sv
module pmpc_default_policy
  import pmpc_pkg::*;
(
  input  logic  deny_default,
  input  logic  lockdown,
  input  logic  machine,
  input  logic  want_exec,
  output perm_t perm,
  output logic  force_deny
);
  always_comb begin
    if (deny_default)                 perm = PERM_NONE;
    else if (lockdown)                perm = (machine && !want_exec) ? PERM_RW : PERM_NONE;
    else                              perm = machine ? PERM_RWX : PERM_NONE;
    force_deny = (perm == PERM_NONE);
  end
endmodule

// File: rtl/pmpc_prio_select.sv
module pmpc_prio_select #(
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     hit,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/pmp_access_checker.sv
module pmp_access_checker
  import pmpc_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 32,
  parameter int SIZE_W      = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [ADDR_W-1:0]             in_addr,
  input  logic [SIZE_W-1:0]             in_size,
  input  logic [2:0]                    in_req,
  input  logic [1:0]                    in_mode,
  input  logic [NUM_ENTRIES*ADDR_W-1:0] region_lo,
  input  logic [NUM_ENTRIES*ADDR_W-1:0] region_hi,
  input  logic [NUM_ENTRIES*8-1:0]      entry_cfg,
  input  logic                          sec_lockdown,
  input  logic                          sec_deny_default,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic                          out_grant,
  output logic [2:0]                    out_allowed
);
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  logic [ADDR_W-1:0]      last_addr;
  logic                   machine;
  logic [NUM_ENTRIES-1:0] touch_vec;
  logic [NUM_ENTRIES-1:0] straddle_vec;
  perm_t                  entry_perm [NUM_ENTRIES];
  logic                   found;
  logic [IDX_W-1:0]       win_idx;
  perm_t                  dflt_perm;
  logic                   dflt_deny;
  perm_t                  allowed_c;
  logic                   deny_c;
  logic                   grant_c;
  logic [NUM_ENTRIES*2-1:0] unused_cfg_bits;

  assign last_addr = in_addr + ADDR_W'(in_size) - ADDR_W'(1);
  assign machine   = (in_mode == PRIV_MACHINE);

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
    logic [7:0] cfg_b;
    assign cfg_b = entry_cfg[g*8 +: 8];
    assign unused_cfg_bits[g*2 +: 2] = cfg_b[6:5];

    pmpc_entry_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .first_addr (in_addr),
      .last_addr  (last_addr),
      .lo         (region_lo[g*ADDR_W +: ADDR_W]),
      .hi         (region_hi[g*ADDR_W +: ADDR_W]),
      .match_mode (cfg_b[CFG_MODE_LSB +: 2]),
      .touch      (touch_vec[g]),
      .straddle   (straddle_vec[g])
    );

    pmpc_perm_lookup u_perm (
      .lockdown (sec_lockdown),
      .machine  (machine),
      .lock     (cfg_b[CFG_LOCK_BIT]),
      .r        (cfg_b[CFG_R_BIT]),
      .w        (cfg_b[CFG_W_BIT]),
      .x        (cfg_b[CFG_X_BIT]),
      .perm     (entry_perm[g])
    );
  end

  pmpc_prio_select #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_sel (
    .hit   (touch_vec),
    .found (found),
    .idx   (win_idx)
  );

  pmpc_default_policy u_dflt (
    .deny_default (sec_deny_default),
    .lockdown     (sec_lockdown),
    .machine      (machine),
    .want_exec    (in_req[CFG_X_BIT]),
    .perm         (dflt_perm),
    .force_deny   (dflt_deny)
  );

  always_comb begin
    if (!found) begin
      allowed_c = dflt_perm;
      deny_c    = dflt_deny;
    end else if (straddle_vec[win_idx]) begin
      allowed_c = PERM_NONE;
      deny_c    = 1'b1;
    end else begin
      allowed_c = entry_perm[win_idx];
      deny_c    = 1'b0;
    end
    grant_c = !deny_c && ((in_req & ~allowed_c) == 3'b000);
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_grant   <= 1'b0;
      out_allowed <= PERM_NONE;
    end else if (in_valid && in_ready) begin
      out_valid   <= 1'b1;
      out_grant   <= grant_c;
      out_allowed <= allowed_c;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/pmpc_checker.sv
module pmpc_checker #(
  parameter int NUM_ENTRIES = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic [2:0]               in_req,
  input logic [1:0]               in_mode,
  input logic [NUM_ENTRIES*8-1:0] entry_cfg,
  input logic                     sec_lockdown,
  input logic                     sec_deny_default,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic                     out_grant,
  input logic [2:0]               out_allowed
);
  logic any_active;
  logic take;

  always_comb begin
    any_active = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++)
      if (entry_cfg[i*8+3 +: 2] != 2'b00) any_active = 1'b1;
    take = in_valid && in_ready;
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_grant) && $stable(out_allowed)); // R1
  AST_READY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R1
  AST_TAKE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid); // R1
  AST_GRANT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!out_grant || (($past(in_req) & ~out_allowed) == 3'b000))); // R11
  AST_DENY_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    take && sec_deny_default && !any_active |=> !out_grant && out_allowed == 3'b000); // R8
  AST_LOCKDOWN_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    take && !sec_deny_default && sec_lockdown && !any_active && in_mode == 2'd3 && !in_req[2]
    |=> out_grant && out_allowed == 3'b011); // R9
  AST_PLAIN_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    take && !sec_deny_default && !sec_lockdown && !any_active && in_mode != 2'd3
    |=> !out_grant && out_allowed == 3'b000); // R10
endmodule

bind pmp_access_checker pmpc_checker #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .in_valid         (in_valid),
  .in_ready         (in_ready),
  .in_req           (in_req),
  .in_mode          (in_mode),
  .entry_cfg        (entry_cfg),
  .sec_lockdown     (sec_lockdown),
  .sec_deny_default (sec_deny_default),
  .out_valid        (out_valid),
  .out_ready        (out_ready),
  .out_grant        (out_grant),
  .out_allowed      (out_allowed)
);

// File: tb/pmp_access_checker_tb.sv
module pmp_access_checker_tb;
  localparam int N  = 8;
  localparam int AW = 32;
  localparam int SW = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [AW-1:0]   in_addr = '0;
  logic [SW-1:0]   in_size = 4'd1;
  logic [2:0]      in_req = '0;
  logic [1:0]      in_mode = '0;
  logic [N*AW-1:0] region_lo = '0;
  logic [N*AW-1:0] region_hi = '0;
  logic [N*8-1:0]  entry_cfg = '0;
  logic            sec_lockdown = 1'b0;
  logic            sec_deny_default = 1'b0;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic            out_grant;
  logic [2:0]      out_allowed;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pmp_access_checker #(.NUM_ENTRIES(N), .ADDR_W(AW), .SIZE_W(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_size(in_size), .in_req(in_req), .in_mode(in_mode),
    .region_lo(region_lo), .region_hi(region_hi), .entry_cfg(entry_cfg),
    .sec_lockdown(sec_lockdown), .sec_deny_default(sec_deny_default),
    .out_valid(out_valid), .out_ready(out_ready), .out_grant(out_grant),
    .out_allowed(out_allowed));

  task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, got, exp);
    end
  endtask

  task automatic set_entry(input int i, input logic [AW-1:0] lo, input logic [AW-1:0] hi,
                           input logic [7:0] cfg);
    region_lo[i*AW +: AW] = lo;
    region_hi[i*AW +: AW] = hi;
    entry_cfg[i*8 +: 8]   = cfg;
  endtask

  task automatic clear_entries();
    region_lo = '0; region_hi = '0; entry_cfg = '0;
  endtask

  // one request through the port; results sampled at the negedge after acceptance
  task automatic send(input logic [AW-1:0] a, input logic [SW-1:0] s,
                      input logic [2:0] rq, input logic [1:0] md);
    @(negedge clk);
    in_addr = a; in_size = s; in_req = rq; in_mode = md; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_result(input string tag, input logic g, input logic [2:0] al);
    chk({tag, " valid"}, {3'b0, out_valid}, 4'd1);
    chk({tag, " grant/allowed"}, {g ? 1'b1 : 1'b0, out_allowed} == {g, al} ? 4'd0 : {out_grant, out_allowed}, 4'd0);
  endtask

  function automatic logic [2:0] tab_m(input logic [3:0] i);
    case (i)
      4'd2, 4'd3, 4'd14: return 3'b011;
      4'd9, 4'd10:       return 3'b100;
      4'd11, 4'd13:      return 3'b101;
      4'd12, 4'd15:      return 3'b001;
      default:           return 3'b000;
    endcase
  endfunction

  function automatic logic [2:0] tab_o(input logic [3:0] i);
    case (i)
      4'd7:               return 3'b111;
      4'd5:               return 3'b101;
      4'd3, 4'd6:         return 3'b011;
      4'd2, 4'd4, 4'd15:  return 3'b001;
      4'd1, 4'd10, 4'd11: return 3'b100;
      default:            return 3'b000;
    endcase
  endfunction

  task automatic t_reset();
    chk("R1 reset out_valid", {3'b0, out_valid}, 4'd0);
    chk("R1 reset in_ready", {3'b0, in_ready}, 4'd1);
  endtask

  task automatic t_defaults();
    clear_entries();
    sec_lockdown = 0; sec_deny_default = 0;
    send(32'h100, 4, 3'b111, 2'd3); chk("R10 machine default", {out_grant, out_allowed}, 4'b1111);
    send(32'h100, 4, 3'b001, 2'd0); chk("R10 user default", {out_grant, out_allowed}, 4'b0000);
    sec_deny_default = 1;
    send(32'h100, 4, 3'b001, 2'd3); chk("R8 deny machine", {out_grant, out_allowed}, 4'b0000);
    send(32'h100, 4, 3'b000, 2'd1); chk("R8 deny empty req", {out_grant, out_allowed}, 4'b0000);
    sec_deny_default = 0; sec_lockdown = 1;
    send(32'h100, 4, 3'b011, 2'd3); chk("R9 machine RW", {out_grant, out_allowed}, 4'b1011);
    send(32'h100, 4, 3'b100, 2'd3); chk("R9 machine exec", {out_grant, out_allowed}, 4'b0000);
    send(32'h100, 4, 3'b001, 2'd1); chk("R9 supervisor", {out_grant, out_allowed}, 4'b0000);
    sec_lockdown = 0;
  endtask

  task automatic t_plain_match();
    clear_entries();
    set_entry(2, 32'h2000, 32'h2FFF, 8'h09);           // active, R only, unlocked
    send(32'h2010, 4, 3'b111, 2'd3); chk("R5 machine unlocked", {out_grant, out_allowed}, 4'b1111);
    send(32'h2010, 4, 3'b001, 2'd0); chk("R5 user R", {out_grant, out_allowed}, 4'b1001);
    send(32'h2010, 4, 3'b011, 2'd0); chk("R11 user RW on R", {out_grant, out_allowed}, 4'b0001);
    set_entry(2, 32'h2000, 32'h2FFF, 8'h89);           // locked
    send(32'h2010, 4, 3'b010, 2'd3); chk("R5 machine locked", {out_grant, out_allowed}, 4'b0001);
    send(32'h2010, 4, 3'b000, 2'd3); chk("R11 empty req", {out_grant, out_allowed}, 4'b1001);
  endtask

  task automatic t_priority();
    clear_entries();
    set_entry(1, 32'h3000, 32'h3FFF, 8'h09);           // R only
    set_entry(4, 32'h3000, 32'h3FFF, 8'h0F);           // RWX
    send(32'h3100, 2, 3'b010, 2'd0); chk("R3 lower index wins", {out_grant, out_allowed}, 4'b0001);
    set_entry(1, 32'h3000, 32'h3FFF, 8'h01);           // mode off
    send(32'h3100, 2, 3'b010, 2'd0); chk("R2 off entry skipped", {out_grant, out_allowed}, 4'b1111);
    send(32'h2FFE, 4, 3'b001, 2'd3); chk("R4 straddle low", {out_grant, out_allowed}, 4'b0000);
    send(32'h3FFC, 4, 3'b001, 2'd0); chk("R4 exact end fits", {out_grant, out_allowed}, 4'b1111);
    set_entry(0, 32'h3FF0, 32'h3FF3, 8'h0F);
    send(32'h3FF2, 4, 3'b001, 2'd3); chk("R3 R4 partial wins", {out_grant, out_allowed}, 4'b0000);
  endtask

  task automatic t_tables();
    clear_entries();
    sec_lockdown = 1;
    for (int i = 0; i < 16; i++) begin
      logic [3:0] ix;
      ix = 4'(i);
      set_entry(0, 32'h5000, 32'h5FFF, {ix[3], 2'b00, 2'b01, ix[0], ix[1], ix[2]});
      send(32'h5004, 4, 3'b000, 2'd3);
      chk($sformatf("R6 machine idx %0d", i), {1'b1, out_allowed}, {1'b1, tab_m(ix)});
      send(32'h5004, 4, 3'b000, 2'd1);
      chk($sformatf("R7 supervisor idx %0d", i), {1'b1, out_allowed}, {1'b1, tab_o(ix)});
    end
    set_entry(0, 32'h5000, 32'h5FFF, 8'h0D);           // {L,R,W,X}=5
    send(32'h5004, 4, 3'b101, 2'd0); chk("R7 R11 user RX", {out_grant, out_allowed}, 4'b1101);
    send(32'h5004, 4, 3'b010, 2'd0); chk("R7 R11 user W", {out_grant, out_allowed}, 4'b0101);
    sec_lockdown = 0;
  endtask

  task automatic t_backpressure();
    clear_entries();
    @(negedge clk);
    out_ready = 0;
    in_addr = 32'h40; in_size = 1; in_req = 3'b111; in_mode = 2'd3; in_valid = 1;
    @(negedge clk);
    in_mode = 2'd0;                                    // second request waits
    chk("R1 valid after take", {3'b0, out_valid}, 4'd1);
    chk("R1 ready low stalled", {3'b0, in_ready}, 4'd0);
    repeat (2) @(negedge clk);
    chk("R1 held while stalled", {out_grant, out_allowed}, 4'b1111);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk("R1 second result", {out_valid, out_grant, out_allowed[1:0]}, 4'b1000);
    @(negedge clk);
    chk("R1 drained", {3'b0, out_valid}, 4'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_defaults();
    t_plain_match();
    t_priority();
    t_tables();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule